// File: doc/BRIEF.md
# Preset-Offset BCD Frequency Counter

This block turns a gated pulse train into a six-digit decimal frequency reading with a resolution of 100 Hz. Each clock cycle in which the pulse enable is high counts as one input pulse. The pulses first pass a divide-by-PRESCALE stage. Each carry from that stage advances a cascade of six BCD decades that covers the digits from 10 MHz down to 100 Hz. With a 100 ms gate and PRESCALE of 10, one cascade step equals 100 Hz.

The measured signal is a mixing product that sits at a fixed offset from the frequency to be shown, and that offset depends on the sideband mode. The block does not subtract the offset. It preloads the cascade with a mode-dependent code and lets the sum wrap past the top decade, so the offset cancels modulo 10^6. A preset strobe loads the code and clears the prescaler. A latch strobe copies the finished count into a holding register that drives the outputs, so the reading stays steady while the next gate runs. A blank flag, the OR of two band bits, tells the display to suppress the 10 MHz digit.

Top module: `freq_preset_counter`

## Requirements
- R1: After reset the cascade, the prescaler and the holding register are all zero, so `digits_o` reads 0x000000.
- R2: The cascade advances by one count for every PRESCALE cycles with `cnt_en` high (default 10). Cycles with `cnt_en` low leave both the prescaler and the cascade unchanged.
- R3: On `preset_ld` the cascade loads the code chosen by `mode_sel`: 2'b00 (lower sideband) gives digits 9,1,0,1,4,0; 2'b01 (upper sideband) gives 9,1,0,1,1,0; 2'b10 and 2'b11 (CW/AM) give 9,1,0,1,1,7. The digits are listed from the top digit `digits_o[23:20]` down to the 100 Hz digit `digits_o[3:0]`.
- R4: `preset_ld` clears the prescaler and takes priority over `cnt_en` in the same cycle. A pulse in that cycle is not counted.
- R5: Every decade holds a value from 0 to 9. A decade at 9 that is advanced wraps to 0 and carries into the next decade up in the same cycle.
- R6: A carry out of the top decade is discarded, so the reading equals (pulses/PRESCALE + preset) mod 10^6.
- R7: On a clock edge with `latch_stb` high, `digits_o` takes the cascade value held before that edge. Without `latch_stb`, `digits_o` does not change.
- R8: `blank_top_o` is high when `band_a` or `band_b` is high, and low only when both are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Gated input pulse, one count per high cycle |
| mode_sel | input | 2 | Sideband mode that selects the preset code |
| preset_ld | input | 1 | Loads the preset and clears the prescaler |
| latch_stb | input | 1 | Copies the cascade into the holding register |
| band_a | input | 1 | Band select bit A |
| band_b | input | 1 | Band select bit B |
| digits_o | output | 24 | Six latched BCD digits, 10 MHz digit in [23:20] |
| blank_top_o | output | 1 | Request to blank the 10 MHz digit |

## Verification
The bench builds two copies of the block from the same stimulus. One uses PRESCALE = 10 to check the divide ratio, the clearing of the prescaler and the handling of gaps in the pulse train. The other uses PRESCALE = 1, where every pulse is one cascade step. With that copy, about ninety thousand cycles push the CW/AM preset past the top decade, so the wrap modulo 10^6 and the multi-decade ripple carry can be reached in a short run. Both copies share the preset, latch and band checks.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  localparam int NDIG = 6;
  localparam int DW   = 4 * NDIG;

  typedef enum logic [1:0] {
    MODE_LSB = 2'b00,
    MODE_USB = 2'b01,
    MODE_CW  = 2'b10,
    MODE_AM  = 2'b11
  } fpc_mode_e;

  // Offset-cancelling code per mode, top digit in the highest nibble (R3)
  function automatic logic [DW-1:0] fpc_preset(input logic [1:0] mode);
    logic [DW-1:0] code;
    case (fpc_mode_e'(mode))
      MODE_LSB: code = 24'h910140;
      MODE_USB: code = 24'h910110;
      default:  code = 24'h910117;
    endcase
    return code;
  endfunction

  // One BCD step with wrap (R5)
  function automatic logic [3:0] bcd_step(input logic [3:0] d);
    return (d == 4'd9) ? 4'd0 : d + 4'd1;
  endfunction

  // True when every nibble is a legal BCD digit (R5)
  function automatic logic bcd_ok(input logic [DW-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < NDIG; i++) begin
      if (v[4*i +: 4] > 4'd9) ok = 1'b0;
    end
    return ok;
  endfunction

endpackage

// File: rtl/fpc_prescaler.sv
module fpc_prescaler #(
  parameter int PRESCALE = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic tick
);

  generate
    if (PRESCALE <= 1) begin : g_pass
      // every enabled pulse is one step
      assign tick = en & ~clr;
    end else begin : g_div
      localparam int CW = $clog2(PRESCALE);
      localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

      logic [CW-1:0] cnt_q;
      logic          at_last;

      assign at_last = (cnt_q == LAST);
      assign tick    = en & ~clr & at_last;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else if (clr) begin
          cnt_q <= '0;
        end else if (en) begin
          cnt_q <= at_last ? '0 : cnt_q + 1'b1;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/fpc_decade.sv
module fpc_decade (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [3:0] load_val,
  input  logic       inc,
  output logic [3:0] q,
  output logic       carry
);

  import fpc_pkg::*;

  logic [3:0] q_r;

  assign q     = q_r;
  assign carry = inc & ~load & (q_r == 4'd9);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= 4'd0;
    end else if (load) begin
      q_r <= load_val;
    end else if (inc) begin
      q_r <= bcd_step(q_r);
    end
  end

endmodule

// File: rtl/fpc_hold.sv
module fpc_hold #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stb,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (stb) begin
      q <= d;
    end
  end

endmodule

// File: rtl/freq_preset_counter.sv
module freq_preset_counter
  import fpc_pkg::*;
#(
  parameter int PRESCALE = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic [1:0]    mode_sel,
  input  logic          preset_ld,
  input  logic          latch_stb,
  input  logic          band_a,
  input  logic          band_b,
  output logic [DW-1:0] digits_o,
  output logic          blank_top_o
);

  // named internal events, observed by the bound checker
  logic            pre_tick;
  logic            top_carry;
  logic [DW-1:0]   casc_q;
  logic [DW-1:0]   preset_val;
  logic [NDIG-1:0] dec_inc;
  logic [NDIG-1:0] dec_carry;

  assign preset_val = fpc_preset(mode_sel);

  fpc_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (preset_ld),
    .en    (cnt_en),
    .tick  (pre_tick)
  );

  generate
    for (genvar g = 0; g < NDIG; g++) begin : g_dec
      if (g == 0) begin : g_lsd
        assign dec_inc[g] = pre_tick;
      end else begin : g_upper
        assign dec_inc[g] = dec_carry[g-1];
      end

      fpc_decade u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (preset_ld),
        .load_val (preset_val[4*g +: 4]),
        .inc      (dec_inc[g]),
        .q        (casc_q[4*g +: 4]),
        .carry    (dec_carry[g])
      );
    end
  endgenerate

  // carry out of the top decade goes nowhere (modulo 10^6)
  assign top_carry = dec_carry[NDIG-1];

  fpc_hold #(.W(DW)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .stb   (latch_stb),
    .d     (casc_q),
    .q     (digits_o)
  );

  assign blank_top_o = band_a | band_b;

endmodule

// File: rtl/fpc_checker.sv
module fpc_checker
  import fpc_pkg::*;
#(
  parameter int PRESCALE = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cnt_en,
  input logic          preset_ld,
  input logic          latch_stb,
  input logic [1:0]    mode_sel,
  input logic          pre_tick,
  input logic          top_carry,
  input logic [DW-1:0] casc_q,
  input logic [DW-1:0] digits_o
);

  assert_bcd_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bcd_ok(casc_q));

  assert_preset_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    preset_ld |=> casc_q == fpc_preset($past(mode_sel)));

  assert_preset_no_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    preset_ld |-> !pre_tick);

  assert_idle_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !preset_ld) |=> $stable(casc_q));

  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_tick && (PRESCALE > 1)) |=> !pre_tick);

  assert_wrap_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    top_carry |=> casc_q == '0);

  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_stb |=> $stable(digits_o));

  assert_latch_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    latch_stb |=> digits_o == $past(casc_q));

endmodule

bind freq_preset_counter fpc_checker #(.PRESCALE(PRESCALE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnt_en    (cnt_en),
  .preset_ld (preset_ld),
  .latch_stb (latch_stb),
  .mode_sel  (mode_sel),
  .pre_tick  (pre_tick),
  .top_carry (top_carry),
  .casc_q    (casc_q),
  .digits_o  (digits_o)
);

// File: tb/freq_preset_counter_tb.sv
`timescale 1ns/1ps
module freq_preset_counter_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic [1:0]  mode_sel = 2'b00;
  logic        preset_ld = 1'b0;
  logic        latch_stb = 1'b0;
  logic        band_a = 1'b0;
  logic        band_b = 1'b0;
  logic [23:0] dig_s;
  logic [23:0] dig_f;
  logic        blank_s;
  logic        blank_f;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  freq_preset_counter #(.PRESCALE(10)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .mode_sel(mode_sel),
    .preset_ld(preset_ld), .latch_stb(latch_stb), .band_a(band_a),
    .band_b(band_b), .digits_o(dig_s), .blank_top_o(blank_s)
  );

  freq_preset_counter #(.PRESCALE(1)) u_dut_p1 (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .mode_sel(mode_sel),
    .preset_ld(preset_ld), .latch_stb(latch_stb), .band_a(band_a),
    .band_b(band_b), .digits_o(dig_f), .blank_top_o(blank_f)
  );

  // preset codes as decimal numbers, from the requirement text
  function automatic int code_of(input logic [1:0] m);
    if (m == 2'b00) return 910140;
    if (m == 2'b01) return 910110;
    return 910117;
  endfunction

  function automatic logic [23:0] to_bcd(input int v);
    logic [23:0] r;
    int x;
    x = v % 1000000;
    for (int i = 0; i < 6; i++) begin
      r[4*i +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [23:0] got, input logic [23:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic chk_both(input string req, input int slow_val, input int fast_val);
    chk({req, " slow"}, dig_s, to_bcd(slow_val));
    chk({req, " fast"}, dig_f, to_bcd(fast_val));
  endtask

  // preset with a pulse present in the same cycle (ignored, R4)
  task automatic do_preset(input logic [1:0] m);
    @(negedge clk);
    mode_sel  = m;
    preset_ld = 1'b1;
    cnt_en    = 1'b1;
    @(negedge clk);
    preset_ld = 1'b0;
    cnt_en    = 1'b0;
  endtask

  task automatic pulses(input int n);
    cnt_en = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic do_latch;
    latch_stb = 1'b1;
    @(negedge clk);
    latch_stb = 1'b0;
  endtask

  task automatic t_mode(input string req, input logic [1:0] m, input int n);
    do_preset(m);
    pulses(n);
    do_latch();
    chk_both(req, n / 10 + code_of(m), n + code_of(m));
  endtask

  task automatic t_reset;
    // R1: everything zero after reset
    chk("R1 reset", dig_s, 24'h000000);
    chk("R1 reset p1", dig_f, 24'h000000);
  endtask

  task automatic t_gaps;
    // R2: idle cycles between pulses are not counted
    do_preset(2'b01);
    for (int i = 0; i < 25; i++) begin
      cnt_en = 1'b1;
      @(negedge clk);
      cnt_en = 1'b0;
      @(negedge clk);
    end
    do_latch();
    chk_both("R2 gapped", 910110 + 2, 910110 + 25);
  endtask

  task automatic t_clear;
    // R4: a second preset clears the partial prescaler count
    do_preset(2'b10);
    pulses(7);
    do_preset(2'b10);
    pulses(5);
    do_latch();
    chk_both("R4 clear", 910117, 910122);
  endtask

  task automatic t_hold;
    // R7: without latch the outputs keep the previous reading
    do_preset(2'b00);
    pulses(30);
    do_latch();
    chk_both("R7 first", 910143, 910170);
    pulses(50);
    chk_both("R7 held", 910143, 910170);
    do_latch();
    chk_both("R7 relatch", 910148, 910220);
  endtask

  task automatic t_band;
    // R8: blank flag is band_a OR band_b
    for (int i = 0; i < 4; i++) begin
      band_a = i[0];
      band_b = i[1];
      @(negedge clk);
      chk("R8 blank", {23'd0, blank_s}, {23'd0, (i != 0)});
      chk("R8 blank p1", {23'd0, blank_f}, {23'd0, (i != 0)});
    end
    band_a = 1'b0;
    band_b = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode("R3 lsb", 2'b00, 0);
    t_mode("R3 usb R2", 2'b01, 37);
    t_mode("R3 cw R2", 2'b10, 125);
    t_mode("R3 am", 2'b11, 0);
    t_gaps();
    t_clear();
    t_mode("R5 ripple", 2'b01, 900);
    t_hold();
    t_mode("R6 wrap", 2'b10, 90000);
    t_band();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 190000 && !done) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule